// File: doc/BRIEF.md
# Multi-channel serial symbol receiver

This block takes six independent serial symbol streams into the system clock domain. Each stream has three wires: a symbol clock, a data line that changes only in step with that clock, and an active-high channel enable. All three may be asynchronous to the system clock. The symbol clock is never used as a clock. It is sampled like any other data signal, and the block looks for high-to-low transitions in the sampled copy.

A channel whose enable is off is ignored. When an enabled channel shows a falling symbol clock edge, the block captures the data bit that was present while the clock was still high. It then reports that bit as a one-cycle strobe together with the channel number.

When several channels produce a bit in the same cycle, the lowest channel number is reported first. The other bits wait in a one-entry holding slot per channel. The system clock must run at least four times faster than the fastest symbol clock.

Top module: `symrx_top`

## Requirements
- R1: A synchronous active-high reset clears all state: `bit_valid`, `bit_val` and `bit_ch` read 0 on the cycle after reset. Whenever `bit_valid` is 0, `bit_ch` and `bit_val` are also 0.
- R2: A falling edge on an enabled channel's symbol clock produces exactly one `bit_valid` pulse, one cycle wide. On an uncontended channel the pulse is high after the fourth rising system clock edge that follows the input change.
- R3: The reported bit is the data line value sampled at the last system clock edge on which the symbol clock was still seen high.
- R4: A falling edge is ignored when the channel's enable is low at the sample that shows the clock low. This covers the case where the enable drops together with the clock.
- R5: A falling edge counts only if the clock was seen high at an earlier sample taken while the enable was high. If the enable rises in the same sample that first shows the clock low, no bit is produced. After re-enable, a normal high-then-low sequence is received again.
- R6: A rising symbol clock edge, or a clock held steady at either level, produces no output.
- R7: When several channels produce bits in the same cycle, they are reported on consecutive cycles in increasing channel order.
- R8: The priority is re-evaluated every cycle. A bit arriving on a lower channel is reported before a higher-channel bit that is still waiting. `bit_valid` is high on a cycle exactly when some bit was waiting or newly arrived on the cycle before.
- R9: `bit_ch` is the channel number in plain binary, from 0 to 5. It never exceeds the channel count minus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_clk | input | 6 | Per-channel symbol clock, asynchronous, bit i is channel i |
| sym_dat | input | 6 | Per-channel symbol data, bit i is channel i |
| sym_en | input | 6 | Per-channel active enable, high = channel on |
| bit_valid | output | 1 | One-cycle strobe for a received bit |
| bit_val | output | 1 | Received bit value, qualified by `bit_valid` |
| bit_ch | output | 3 | Channel number of the received bit |

## Verification
The path from an input pin to the output strobe has a fixed length. Two synchronizer flops are followed by the edge history, the registered event and the registered arbiter output. An uncontended fall driven between edges therefore shows on `bit_valid` after the fourth following rising edge. Each additional waiting channel adds one cycle, in channel order.

The bench keeps its own per-sample history of the inputs. Every event it derives is held for three cycles, and then one arbitration step runs per cycle. Outputs are compared on every falling system clock edge, half a period after they change.

Scenario checks wait for the pipeline to drain before they read the pulse counts and the arrival order. The first-strobe latency is measured directly as the fourth falling edge after the stimulus.

// File: rtl/symrx_pkg.sv
`timescale 1ns/1ps
package symrx_pkg;
  // extra data delay so the captured bit lines up with the last high clock sample
  localparam int unsigned DATA_EXTRA = 1;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/symrx_sync.sv
`timescale 1ns/1ps
module symrx_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= din;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/symrx_chan.sv
`timescale 1ns/1ps
module symrx_chan (
  input  logic clk,
  input  logic rst,
  input  logic clk_s,
  input  logic en_s,
  input  logic dat_d,
  output logic ev_q,
  output logic bit_q
);
  logic clk_prev;
  logic fall;

  // the history only remembers a high clock when it was seen with the enable on
  assign fall = en_s & clk_prev & ~clk_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_prev <= 1'b0;
      ev_q     <= 1'b0;
      bit_q    <= 1'b0;
    end else begin
      clk_prev <= en_s & clk_s;
      ev_q     <= fall;
      if (fall) bit_q <= dat_d;
    end
  end
endmodule

// File: rtl/symrx_arb.sv
`timescale 1ns/1ps
module symrx_arb #(
  parameter int unsigned N_CH = 6,
  parameter int unsigned CH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH-1:0] ev,
  input  logic [N_CH-1:0] evbit,
  output logic [N_CH-1:0] req_o,
  output logic            bit_valid,
  output logic            bit_val,
  output logic [CH_W-1:0] bit_ch
);
  logic [N_CH-1:0] pend, pbit, req, rbit, grant;
  logic [CH_W-1:0] sel;
  logic            any;

  always_comb begin
    req = pend | ev;
    for (int i = 0; i < N_CH; i++) rbit[i] = ev[i] ? evbit[i] : pbit[i];
    sel = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (req[i]) sel = CH_W'(i);
    end
    any   = |req;
    grant = '0;
    if (any) grant[sel] = 1'b1;
  end

  assign req_o = req;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= '0;
      pbit      <= '0;
      bit_valid <= 1'b0;
      bit_val   <= 1'b0;
      bit_ch    <= '0;
    end else begin
      pend      <= req & ~grant;
      pbit      <= rbit;
      bit_valid <= any;
      bit_val   <= any & rbit[sel];
      bit_ch    <= any ? sel : '0;
    end
  end
endmodule

// File: rtl/symrx_top.sv
`timescale 1ns/1ps
module symrx_top #(
  parameter int unsigned N_CH        = 6,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CH_W       = symrx_pkg::idx_width(N_CH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH-1:0] sym_clk,
  input  logic [N_CH-1:0] sym_dat,
  input  logic [N_CH-1:0] sym_en,
  output logic            bit_valid,
  output logic            bit_val,
  output logic [CH_W-1:0] bit_ch
);
  localparam int unsigned DAT_STAGES = SYNC_STAGES + symrx_pkg::DATA_EXTRA;

  logic [N_CH-1:0] clk_s, en_s, dat_d;
  logic [N_CH-1:0] ev_q, bit_q, arb_req;

  symrx_sync #(.WIDTH(2*N_CH), .STAGES(SYNC_STAGES)) u_sync_ce (
    .clk (clk),
    .rst (rst),
    .din ({sym_en, sym_clk}),
    .dout({en_s, clk_s})
  );

  symrx_sync #(.WIDTH(N_CH), .STAGES(DAT_STAGES)) u_sync_d (
    .clk (clk),
    .rst (rst),
    .din (sym_dat),
    .dout(dat_d)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    symrx_chan u_chan (
      .clk  (clk),
      .rst  (rst),
      .clk_s(clk_s[g]),
      .en_s (en_s[g]),
      .dat_d(dat_d[g]),
      .ev_q (ev_q[g]),
      .bit_q(bit_q[g])
    );
  end

  symrx_arb #(.N_CH(N_CH), .CH_W(CH_W)) u_arb (
    .clk      (clk),
    .rst      (rst),
    .ev       (ev_q),
    .evbit    (bit_q),
    .req_o    (arb_req),
    .bit_valid(bit_valid),
    .bit_val  (bit_val),
    .bit_ch   (bit_ch)
  );
endmodule

// File: rtl/symrx_chk.sv
`timescale 1ns/1ps
module symrx_chk #(
  parameter int unsigned N_CH = 6,
  parameter int unsigned CH_W = 3
) (
  input logic            clk,
  input logic            rst,
  input logic [N_CH-1:0] sym_clk,
  input logic [N_CH-1:0] sym_dat,
  input logic [N_CH-1:0] sym_en,
  input logic [N_CH-1:0] ev_q,
  input logic [N_CH-1:0] bit_q,
  input logic [N_CH-1:0] req,
  input logic            bit_valid,
  input logic            bit_val,
  input logic [CH_W-1:0] bit_ch
);
  logic [N_CH-1:0] req_prev;
  logic [N_CH-1:0] lowmask;

  always_ff @(posedge clk) begin
    if (rst) req_prev <= '0;
    else     req_prev <= req;
  end

  assign lowmask = (N_CH'(1) << bit_ch) - N_CH'(1);

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> !bit_valid);
  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |-> (bit_ch == '0 && !bit_val));
  // R9
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> (int'(bit_ch) < N_CH));
  // R8
  valid_src_chk: assert property (@(posedge clk) disable iff (rst)
    bit_valid == (req_prev != '0));
  // R7
  prio_chk: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> (req_prev[bit_ch] && (req_prev & lowmask) == '0));

  for (genvar g = 0; g < N_CH; g++) begin : g_pc
    // R4
    en_gate_chk: assert property (@(posedge clk) disable iff (rst)
      ev_q[g] |-> $past(sym_en[g], 3));
    // R5
    hist_en_chk: assert property (@(posedge clk) disable iff (rst)
      ev_q[g] |-> $past(sym_en[g], 4));
    // R6
    fall_only_chk: assert property (@(posedge clk) disable iff (rst)
      ev_q[g] |-> ($past(sym_clk[g], 4) && !$past(sym_clk[g], 3)));
    // R3
    data_cap_chk: assert property (@(posedge clk) disable iff (rst)
      ev_q[g] |-> (bit_q[g] == $past(sym_dat[g], 4)));
  end
endmodule

bind symrx_top symrx_chk #(.N_CH(N_CH), .CH_W(CH_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sym_clk  (sym_clk),
  .sym_dat  (sym_dat),
  .sym_en   (sym_en),
  .ev_q     (ev_q),
  .bit_q    (bit_q),
  .req      (arb_req),
  .bit_valid(bit_valid),
  .bit_val  (bit_val),
  .bit_ch   (bit_ch)
);

// File: tb/symrx_top_bench.sv
`timescale 1ns/1ps
module symrx_top_bench;
  localparam int N = 6;
  localparam int W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] sc = '0, sd = '0, se = '0;
  logic bv, bb;
  logic [W-1:0] bc;

  always #2.5 clk = ~clk;

  symrx_top u_symrx_top (
    .clk(clk), .rst(rst), .sym_clk(sc), .sym_dat(sd), .sym_en(se),
    .bit_valid(bv), .bit_val(bb), .bit_ch(bc)
  );

  int nchk = 0, nerr = 0;
  bit done = 1'b0, run_cmp = 1'b0;
  int cnt[N];
  int ord[$];
  bit obit[$];

  // behavioural reference: per-sample history, 3-cycle event delay, one grant per cycle
  bit pc[N], pd[N], pe[N];
  bit evA[N], evB[N], evC[N], bA[N], bB[N], bC[N];
  bit pm[N], pb[N];
  bit exp_v, exp_b;
  int exp_c;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        pc[i]=0; pd[i]=0; pe[i]=0; evA[i]=0; evB[i]=0; evC[i]=0;
        bA[i]=0; bB[i]=0; bC[i]=0; pm[i]=0; pb[i]=0;
      end
      exp_v = 0; exp_b = 0; exp_c = 0;
    end else begin
      exp_v = 0; exp_b = 0; exp_c = 0;
      for (int i = N-1; i >= 0; i--) begin
        if (pm[i] || evC[i]) begin
          exp_v = 1; exp_c = i; exp_b = evC[i] ? bC[i] : pb[i];
        end
      end
      for (int i = 0; i < N; i++) begin
        bit r;
        r = pm[i] || evC[i];
        if (evC[i]) pb[i] = bC[i];
        pm[i] = r && !(exp_v && exp_c == i);
      end
      for (int i = 0; i < N; i++) begin
        evC[i] = evB[i]; bC[i] = bB[i];
        evB[i] = evA[i]; bB[i] = bA[i];
        evA[i] = se[i] && pe[i] && pc[i] && !sc[i];
        bA[i]  = pd[i];
        pc[i] = sc[i]; pd[i] = sd[i]; pe[i] = se[i];
      end
    end
  end

  task automatic chk_eq(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (run_cmp && !done) begin
      chk_eq("R2 R3 R7 R8 model valid", int'(bv), int'(exp_v));
      chk_eq("R7 R9 model channel", int'(bc), exp_c);
      chk_eq("R3 model bit", int'(bb), int'(exp_b));
      if (bv) begin
        cnt[bc]++;
        ord.push_back(int'(bc));
        obit.push_back(bb);
      end
    end
  end

  task automatic clr;
    for (int i = 0; i < N; i++) cnt[i] = 0;
    ord.delete();
    obit.delete();
  endtask

  function automatic int total();
    int t = 0;
    for (int i = 0; i < N; i++) t += cnt[i];
    return t;
  endfunction

  task automatic settle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic fall_one(int ch, bit dv);
    @(negedge clk); sc[ch] = 1'b1; sd[ch] = dv;
    repeat (3) @(negedge clk); sc[ch] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nerr++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 100000, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int got;
    rst = 1'b1;
    @(negedge clk); run_cmp = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_eq("R1 reset valid", int'(bv), 0);
    chk_eq("R1 reset ch", int'(bc), 0);
    chk_eq("R1 reset bit", int'(bb), 0);
    rst = 1'b0;
    se = '1;
    settle(4);

    // R2 latency on an idle channel
    clr();
    @(negedge clk); sc[1] = 1'b1; sd[1] = 1'b1;
    repeat (3) @(negedge clk); sc[1] = 1'b0;
    got = 0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (bv && got == 0) got = k;
    end
    chk_eq("R2 first strobe latency", got, 4);
    #1;
    chk_eq("R2 one pulse per fall", cnt[1], 1);

    // R2 R3 R9 single channels with different data
    clr();
    fall_one(2, 1'b1); fall_one(0, 1'b0); fall_one(5, 1'b1);
    settle(8);
    chk_eq("R2 total pulses", total(), 3);
    chk_eq("R9 order first ch", ord[0], 2);
    chk_eq("R9 order second ch", ord[1], 0);
    chk_eq("R9 order third ch", ord[2], 5);
    chk_eq("R3 bit ch2", int'(obit[0]), 1);
    chk_eq("R3 bit ch0", int'(obit[1]), 0);
    chk_eq("R3 bit ch5", int'(obit[2]), 1);

    // R4 disabled channel ignored
    clr();
    se[3] = 1'b0;
    fall_one(3, 1'b1); fall_one(3, 1'b0);
    settle(8);
    chk_eq("R4 disabled channel pulses", total(), 0);
    // R4 enable drops together with the clock
    clr();
    se[3] = 1'b1;
    @(negedge clk); sc[3] = 1'b1;
    repeat (3) @(negedge clk); sc[3] = 1'b0; se[3] = 1'b0;
    settle(8);
    chk_eq("R4 enable drops with clock", total(), 0);
    se[3] = 1'b1;

    // R5 stale high clock before enable
    clr();
    se[4] = 1'b0;
    @(negedge clk); sc[4] = 1'b1;
    repeat (4) @(negedge clk); sc[4] = 1'b0; se[4] = 1'b1;
    settle(8);
    chk_eq("R5 stale edge on re-enable", total(), 0);
    clr();
    fall_one(4, 1'b1);
    settle(6);
    chk_eq("R5 normal fall after re-enable", cnt[4], 1);

    // R6 rising edge only, then a long low
    clr();
    @(negedge clk); sc[1] = 1'b1;
    settle(10);
    chk_eq("R6 rising edge only", total(), 0);
    @(negedge clk); sc[1] = 1'b0;
    settle(20);
    chk_eq("R2 one pulse on long low", cnt[1], 1);

    // R7 all channels fall together
    clr();
    @(negedge clk); sc = '1; sd = 6'b101101;
    repeat (3) @(negedge clk); sc = '0;
    settle(14);
    chk_eq("R7 burst count", total(), N);
    for (int i = 0; i < N && i < ord.size(); i++) begin
      chk_eq("R7 burst order", ord[i], i);
      chk_eq("R3 burst bit", int'(obit[i]), int'(sd[i]));
    end

    // R8 lower channel overtakes a waiting higher one
    clr();
    @(negedge clk); sc[5] = 1'b1; sc[4] = 1'b1; sc[0] = 1'b1; sd = '0;
    repeat (3) @(negedge clk); sc[5] = 1'b0; sc[4] = 1'b0;
    @(negedge clk); sc[0] = 1'b0;
    settle(10);
    chk_eq("R8 count", total(), 3);
    if (ord.size() == 3) begin
      chk_eq("R8 first", ord[0], 4);
      chk_eq("R8 second", ord[1], 0);
      chk_eq("R8 third", ord[2], 5);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule